// File: doc/BRIEF.md
# Four-Source Vectored Interrupt Controller

This block is the interrupt controller of a small 4-bit processor core. It has four sources: an external pin, two timers and a port falling-edge detector. For each source it keeps one request flag and one enable flag. Software reads and writes the flags as two 4-bit system registers. A source can raise an interrupt only when both of its flags are 1.

The external source watches bit 0 of the first port. The raw pin passes through a two-stage synchronizer. The synchronized value is then ANDed with that port's output latch. A falling edge of the result sets the external request flag, but only while the external enable is 1. Because of the AND, software that writes 0 to the latch also raises the request. The two timers and the port edge detector supply one-cycle set pulses directly.

A sequencer counts instruction-boundary strobes from the processor. Suppose an instruction ends while an enabled request is pending. Service then starts once two further instructions have completed. If the pending condition disappears before that, the service is cancelled. On acceptance the block asks the processor to push the PC and the carry flag, and it clears every enable flag. In the next cycle it loads the vector of the highest-priority source.

Sequencer states:

| State | Meaning | Next state |
|---|---|---|
| `S_IDLE` | No service under way | `S_HOLD1` when a boundary arrives while pending |
| `S_HOLD1` | Waiting for the first following instruction to end | `S_HOLD2` on a boundary; `S_IDLE` if pending drops |
| `S_HOLD2` | Waiting for the second following instruction to end | `S_STACK` on a boundary; `S_IDLE` if pending drops |
| `S_STACK` | Push request and enable clear | `S_VECT` unconditionally |
| `S_VECT` | Vector load | `S_IDLE` unconditionally |

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, both system registers read 0, and `push_req` and `vec_load` are 0.
- R2: Address 0 (`sr_addr`=0) holds the enables and address 1 holds the requests. In both, bit 3 is the external source, bit 2 is timer 0, bit 1 is timer 1 and bit 0 is the port edge source. A write replaces the addressed register.
- R3: `tmr0_req`, `tmr1_req` and `pedge_req` set request bits 2, 1 and 0 whatever the enables are. A set bit stays set until software writes 0 to it. A hardware set in the same cycle as a software clear leaves the bit at 1.
- R4: While enable bit 3 is 1, request bit 3 is set as follows:
  - A falling `ext_pin` shows in the read data two clock edges after the first edge that samples it low.
  - A falling `ext_latch` shows after one edge.
  - While enable bit 3 is 0, a falling pin leaves request bit 3 at 0.
- R5: No push and no vector load take place unless some source has both its request bit and its enable bit at 1.
- R6: The instruction that ends at a strobe with an enabled request pending counts as instruction N. Two further strobes follow. In the cycle after the second one, `push_req` is 1 for one cycle, with `push_pc`=`pc_in` and `push_carry`=`carry_in`. In the next cycle `vec_load` is 1 for one cycle. Neither signal is asserted before then.
- R7: Service is cancelled, with no push and no vector, if the pending condition drops between instruction N and the second following strobe. This applies whether software clears the enable or the request.
- R8: The source with the higher bit index wins. The vectors are 0x004 for external, 0x008 for timer 0, 0x00C for timer 1 and 0x010 for port edge.
- R9: Acceptance clears all four enable bits and leaves the request bits unchanged.
- R10: Software may re-enable sources inside a handler. A still-pending request then starts a new service through the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_wr | input | 1 | System register write strobe |
| sr_addr | input | 1 | Register select: 0 enables, 1 requests |
| sr_wdata | input | 4 | Write data |
| sr_rdata | output | 4 | Read data of the selected register |
| ext_pin | input | 1 | Raw level of port A bit 0 |
| ext_latch | input | 1 | Port A bit 0 output latch value |
| tmr0_req | input | 1 | Timer 0 request pulse |
| tmr1_req | input | 1 | Timer 1 request pulse |
| pedge_req | input | 1 | Port falling-edge detector request pulse |
| instr_done | input | 1 | Instruction boundary strobe |
| pc_in | input | PC_W | Current program counter |
| carry_in | input | 1 | Current carry flag |
| push_req | output | 1 | Stack push request |
| push_pc | output | PC_W | PC value to push |
| push_carry | output | 1 | Carry value to push |
| vec_load | output | 1 | Load `vec_addr` into the PC |
| vec_addr | output | PC_W | Vector address |

## Verification
Two pairs of events can land in the same clock cycle. First, a hardware set of a request bit can coincide with a software write that clears that register. The bench provokes this by raising `tmr1_req` and issuing a register-1 write of 0 in one cycle. It expects only bit 1 to survive. Second, the acceptance clear of the enables can coincide with the vector selection, which still needs those enables. The priority table judges this case: every entry must load the correct vector, and the enable register must read 0 afterwards.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned NSRC = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HOLD1,
        S_HOLD2,
        S_STACK,
        S_VECT
    } seq_state_t;
endpackage

// File: rtl/irqc_extedge.sv
module irqc_extedge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic out_latch,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    logic                   prev_q;

    // Sync chain resets high so that a quiet pin gives no spurious edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
            prev_q <= level;
        end
    end

    // The effective level falls when either the pin or the latch goes low.
    assign level = sync_q[SYNC_STAGES-1] & out_latch;
    assign fall  = prev_q & ~level;
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_wr,
    input  logic            sw_sel,
    input  logic [NSRC-1:0] sw_data,
    input  logic [NSRC-1:0] hw_set,
    input  logic            accept_clr,
    output logic [NSRC-1:0] ie_q,
    output logic [NSRC-1:0] irq_q
);
    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        logic set_g;
        logic ie_b;
        logic irq_b;

        // Only the top (external) source is gated by its own enable.
        if (g == NSRC - 1) begin : g_gated
            assign set_g = hw_set[g] & ie_b;
        end else begin : g_plain
            assign set_g = hw_set[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ie_b  <= 1'b0;
                irq_b <= 1'b0;
            end else begin
                if (accept_clr)
                    ie_b <= 1'b0;
                else if (sw_wr && !sw_sel)
                    ie_b <= sw_data[g];

                // A hardware set wins over a same-cycle software clear.
                if (sw_wr && sw_sel)
                    irq_b <= sw_data[g] | set_g;
                else
                    irq_b <= irq_b | set_g;
            end
        end

        assign ie_q[g]  = ie_b;
        assign irq_q[g] = irq_b;
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NSRC     = 4,
    parameter int VEC_W    = 12,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic [NSRC-1:0]  active,
    output logic             any_act,
    output logic [VEC_W-1:0] vec
);
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [SEL_W-1:0] sel;

    // Later iterations override, so the highest active index wins.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (active[i])
                sel = SEL_W'(i);
        end
    end

    assign any_act = |active;
    assign vec     = any_act ? VEC_W'(VEC_BASE + VEC_STEP * (NSRC - 1 - int'(sel))) : '0;
endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_done,
    input  logic            pending,
    input  logic [PC_W-1:0] vec_sel,
    input  logic [PC_W-1:0] pc_in,
    input  logic            carry_in,
    output logic            push_req,
    output logic [PC_W-1:0] push_pc,
    output logic            push_carry,
    output logic            vec_load,
    output logic [PC_W-1:0] vec_addr,
    output logic            accept_clr
);
    seq_state_t state_q, state_d;
    logic [PC_W-1:0] vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // The vector is captured while the enables still hold their pre-accept values.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  vec_q <= '0;
        else if (state_q == S_STACK) vec_q <= vec_sel;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (pending && instr_done) state_d = S_HOLD1;
            S_HOLD1: if (!pending) state_d = S_IDLE;
                     else if (instr_done) state_d = S_HOLD2;
            S_HOLD2: if (!pending) state_d = S_IDLE;
                     else if (instr_done) state_d = S_STACK;
            S_STACK: state_d = S_VECT;
            S_VECT:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        push_req   = 1'b0;
        push_pc    = '0;
        push_carry = 1'b0;
        vec_load   = 1'b0;
        vec_addr   = '0;
        accept_clr = 1'b0;
        unique case (state_q)
            S_STACK: begin
                push_req   = 1'b1;
                push_pc    = pc_in;
                push_carry = carry_in;
                accept_clr = 1'b1;
            end
            S_VECT: begin
                vec_load = 1'b1;
                vec_addr = vec_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int PC_W        = 12,
    parameter int SYNC_STAGES = 2,
    parameter int VEC_BASE    = 4,
    parameter int VEC_STEP    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sr_wr,
    input  logic            sr_addr,
    input  logic [3:0]      sr_wdata,
    output logic [3:0]      sr_rdata,
    input  logic            ext_pin,
    input  logic            ext_latch,
    input  logic            tmr0_req,
    input  logic            tmr1_req,
    input  logic            pedge_req,
    input  logic            instr_done,
    input  logic [PC_W-1:0] pc_in,
    input  logic            carry_in,
    output logic            push_req,
    output logic [PC_W-1:0] push_pc,
    output logic            push_carry,
    output logic            vec_load,
    output logic [PC_W-1:0] vec_addr
);
    logic [NSRC-1:0] ie_q, irq_q, hw_set;
    logic            ext_fall, pending, accept_clr;
    logic [PC_W-1:0] vec_sel;

    irqc_extedge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk(clk), .rst_n(rst_n), .pin_raw(ext_pin), .out_latch(ext_latch), .fall(ext_fall)
    );

    assign hw_set = {ext_fall, tmr0_req, tmr1_req, pedge_req};

    irqc_flags #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .sw_wr(sr_wr), .sw_sel(sr_addr), .sw_data(sr_wdata),
        .hw_set(hw_set), .accept_clr(accept_clr), .ie_q(ie_q), .irq_q(irq_q)
    );

    irqc_prio #(.NSRC(NSRC), .VEC_W(PC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_prio (
        .active(ie_q & irq_q), .any_act(pending), .vec(vec_sel)
    );

    irqc_seq #(.PC_W(PC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .pending(pending),
        .vec_sel(vec_sel), .pc_in(pc_in), .carry_in(carry_in),
        .push_req(push_req), .push_pc(push_pc), .push_carry(push_carry),
        .vec_load(vec_load), .vec_addr(vec_addr), .accept_clr(accept_clr)
    );

    assign sr_rdata = sr_addr ? irq_q : ie_q;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
    parameter int PC_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      ie_q,
    input logic [3:0]      irq_q,
    input logic            sr_wr,
    input logic            sr_addr,
    input logic            tmr0_req,
    input logic            ext_pin,
    input logic            push_req,
    input logic            vec_load,
    input logic [PC_W-1:0] vec_addr
);
    a_r5_push_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> (|(ie_q & irq_q)));

    a_r6_vector_follows_push: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> vec_load);

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_req && vec_load));

    a_r8_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> (vec_addr == PC_W'(4) || vec_addr == PC_W'(8) ||
                      vec_addr == PC_W'(12) || vec_addr == PC_W'(16)));

    a_r9_enables_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> (ie_q == 4'b0000));

    a_r3_timer0_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tmr0_req |=> irq_q[2]);

    a_r4_ext_ignored_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_q[3] && !irq_q[3] && !(sr_wr && sr_addr) && $stable(ext_pin)) |=> !irq_q[3]);
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ie_q(ie_q), .irq_q(irq_q), .sr_wr(sr_wr), .sr_addr(sr_addr),
    .tmr0_req(tmr0_req), .ext_pin(ext_pin), .push_req(push_req), .vec_load(vec_load),
    .vec_addr(vec_addr)
);

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
    localparam int PC_W = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic sr_wr, sr_addr;
    logic [3:0] sr_wdata, sr_rdata;
    logic ext_pin, ext_latch, tmr0_req, tmr1_req, pedge_req, instr_done, carry_in;
    logic [PC_W-1:0] pc_in, push_pc, vec_addr;
    logic push_req, push_carry, vec_load;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    vec_irq_ctrl #(.PC_W(PC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .sr_addr(sr_addr), .sr_wdata(sr_wdata),
        .sr_rdata(sr_rdata), .ext_pin(ext_pin), .ext_latch(ext_latch), .tmr0_req(tmr0_req),
        .tmr1_req(tmr1_req), .pedge_req(pedge_req), .instr_done(instr_done), .pc_in(pc_in),
        .carry_in(carry_in), .push_req(push_req), .push_pc(push_pc), .push_carry(push_carry),
        .vec_load(vec_load), .vec_addr(vec_addr)
    );

    // Each row: enables, requests, expected vector (0 = no service).
    localparam logic [19:0] TBL [8] = '{
        {4'hF, 4'hF, 12'h004}, {4'h7, 4'hF, 12'h008}, {4'h3, 4'hF, 12'h00C},
        {4'h1, 4'hF, 12'h010}, {4'h5, 4'h3, 12'h010}, {4'hA, 4'h6, 12'h00C},
        {4'hC, 4'h4, 12'h008}, {4'hC, 4'h3, 12'h000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [3:0] d);
        @(negedge clk);
        sr_wr = 1'b1; sr_addr = a; sr_wdata = d;
        @(negedge clk);
        sr_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [3:0] v);
        sr_addr = a;
        #1;
        v = sr_rdata;
    endtask

    task automatic boundary();
        @(negedge clk);
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] v;
        rst_n = 1'b0; sr_wr = 1'b0; sr_addr = 1'b0; sr_wdata = '0;
        ext_pin = 1'b1; ext_latch = 1'b1; tmr0_req = 1'b0; tmr1_req = 1'b0;
        pedge_req = 1'b0; instr_done = 1'b0; pc_in = '0; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(1'b0, v); chk("R1 enables", v, 0);
        rd(1'b1, v); chk("R1 requests", v, 0);
        chk("R1 push", push_req, 0);
        chk("R1 vec", vec_load, 0);
        rst_n = 1'b1;

        // Priority table (R2, R5, R6, R8, R9).
        for (int k = 0; k < 8; k++) begin
            logic [3:0] t_ie, t_irq;
            logic [11:0] t_vec;
            {t_ie, t_irq, t_vec} = TBL[k];
            pc_in = PC_W'(12'h111 * (k + 1));
            carry_in = k[0];
            wr(1'b1, t_irq);
            wr(1'b0, t_ie);
            rd(1'b1, v); chk("R2 request readback", v, t_irq);
            boundary();
            boundary();
            chk("R6 no early push", push_req, 0);
            boundary();
            if (t_vec != 0) begin
                chk("R6 push", push_req, 1);
                chk("R6 push pc", push_pc, pc_in);
                chk("R6 push carry", push_carry, carry_in);
                @(negedge clk);
                chk("R6 vec load", vec_load, 1);
                chk("R8 vector", vec_addr, t_vec);
                rd(1'b0, v); chk("R9 enables cleared", v, 0);
                rd(1'b1, v); chk("R9 requests kept", v, t_irq);
            end else begin
                chk("R5 no push", push_req, 0);
                @(negedge clk);
                chk("R5 no vec", vec_load, 0);
                wr(1'b0, 4'h0);
            end
            wr(1'b1, 4'h0);
        end

        // R3: timer and port sources, sticky, hw set beats sw clear.
        @(negedge clk); tmr0_req = 1'b1;
        @(negedge clk); tmr0_req = 1'b0;
        rd(1'b1, v); chk("R3 timer0 sets bit2", v, 4'b0100);
        @(negedge clk); pedge_req = 1'b1;
        @(negedge clk); pedge_req = 1'b0;
        repeat (3) @(negedge clk);
        rd(1'b1, v); chk("R3 flags sticky", v, 4'b0101);
        @(negedge clk);
        tmr1_req = 1'b1; sr_wr = 1'b1; sr_addr = 1'b1; sr_wdata = 4'h0;
        @(negedge clk);
        tmr1_req = 1'b0; sr_wr = 1'b0;
        rd(1'b1, v); chk("R3 set wins over clear", v, 4'b0010);
        wr(1'b1, 4'h0);

        // R4: external pin ignored while disabled.
        @(negedge clk); ext_pin = 1'b0;
        repeat (5) @(negedge clk);
        rd(1'b1, v); chk("R4 ignored when disabled", v, 0);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        wr(1'b0, 4'h8);
        @(negedge clk); ext_pin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd(1'b1, v); chk("R4 pin not yet", v[3], 0);
        @(negedge clk);
        rd(1'b1, v); chk("R4 pin edge sets", v[3], 1);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        wr(1'b1, 4'h0);
        @(negedge clk); ext_latch = 1'b0;
        @(negedge clk);
        rd(1'b1, v); chk("R4 latch write sets", v[3], 1);
        ext_latch = 1'b1;
        repeat (2) @(negedge clk);
        wr(1'b0, 4'h0);
        wr(1'b1, 4'h0);

        // R7: cancel by clearing the request, then by clearing the enable.
        wr(1'b1, 4'h2); wr(1'b0, 4'h2);
        boundary(); boundary();
        wr(1'b1, 4'h0);
        boundary();
        chk("R7 cancel by request", push_req, 0);
        @(negedge clk);
        chk("R7 no vector", vec_load, 0);
        wr(1'b0, 4'h0);
        wr(1'b1, 4'h1); wr(1'b0, 4'h1);
        boundary();
        wr(1'b0, 4'h0);
        boundary(); boundary();
        chk("R7 cancel by enable", push_req, 0);
        wr(1'b1, 4'h0);

        // R10: nested service after re-enable inside the handler.
        wr(1'b1, 4'h6); wr(1'b0, 4'h6);
        boundary(); boundary(); boundary();
        chk("R10 first push", push_req, 1);
        @(negedge clk);
        chk("R10 first vector", vec_addr, 12'h008);
        wr(1'b0, 4'h2);
        boundary(); boundary(); boundary();
        chk("R10 nested push", push_req, 1);
        @(negedge clk);
        chk("R10 nested vector", vec_addr, 12'h00C);
        wr(1'b1, 4'h0);

        summary();
        $finish;
    end
endmodule